// File: doc/BRIEF.md
# Multi-Processor Device Interrupt Router

This block collects up to 64 device interrupt request lines into one shared pending vector and distributes them to as many as four processors. Every processor owns a 64-bit enable mask; its routed vector is the mask ANDed with the pending vector, and its interrupt output is high while any routed bit is set. Devices raise and drop pending bits with separate set and clear strobes that each carry an interrupt number. Software reads the pending vector, reads and writes the masks, and reads the routed vectors through a 64-bit register port.

The routed vectors are recomputed on every mask write and on every change of the pending vector. For each processor a one-cycle post vector marks the bits whose routed value has just risen, and a one-cycle withdraw vector marks those that have just fallen. Only processors below the `NUM_CPU` parameter drive interrupts and events. Masks and routed vectors of absent processors are still stored and readable.

Top module: `irq_router`

## Requirements
- R1: After reset the pending vector, all masks, all routed vectors, `cpu_irq`, the event vectors and all flags are zero.
- R2: A set strobe with number n makes pending bit n one in the cycle after the strobe.
- R3: A clear strobe with number n makes pending bit n zero in the cycle after the strobe. If bit n was already zero, nothing changes and `spurious_clr` pulses high for one cycle.
- R4: When set and clear strobes fall in the same cycle, the clear is applied first and the set second, so a shared number ends up set.
- R5: Every processor's routed vector equals its mask ANDed with the pending vector, in every cycle after the change that caused it.
- R6: For a present processor, `post_evt` has, for one cycle, exactly the routed bits that went from 0 to 1. `wdraw_evt` has, for one cycle, exactly the routed bits that went from 1 to 0.
- R7: `cpu_irq[c]` is the OR of routed vector c for c < `NUM_CPU`. For absent processors `cpu_irq`, `post_evt` and `wdraw_evt` stay zero, although their masks and routed vectors are kept.
- R8: The register index is `bus_addr >> 6` and the low six address bits are ignored. Index 0 is the pending vector (read-only). Index 1+c is the mask of processor c (read/write). Index 8+c is the routed vector of processor c (read-only). Other indices read as zero.
- R9: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. The data is the state that held before that edge.
- R10: An access with `bus_size` other than 8 bytes pulses `size_err` in the next cycle. It changes no state, and a read of this kind returns zero.
- R11: A full-size write to any index other than a mask pulses `ro_err` in the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_vld | input | 1 | Raise-request strobe |
| req_set_num | input | 6 | Interrupt number to raise |
| req_clr_vld | input | 1 | Drop-request strobe |
| req_clr_num | input | 6 | Interrupt number to drop |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| size_err | output | 1 | Illegal access size pulse |
| ro_err | output | 1 | Write to a non-writable index pulse |
| spurious_clr | output | 1 | Clear of a bit that was not pending |
| cpu_irq | output | 4 | Per-processor level device interrupt |
| post_evt | output | 256 | Per-processor bits that rose, 64 per processor |
| wdraw_evt | output | 256 | Per-processor bits that fell, 64 per processor |

## Verification
The hardest case to reach is a cycle where a mask write, a set strobe and a clear strobe all land at once. In that cycle the routed vector has to be computed from the new mask and the already updated pending vector, and post and withdraw bits can both appear for one processor. The stimulus runs long pseudo-random phases in which all three sources fire independently and the set and clear numbers are drawn from a narrow range, so they often collide. A behavioural model works out the expected routed state bit by bit from the new mask and pending values and compares it every clock. The bench instance has three processors present, so the stored-but-silent fourth lane is also covered.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int unsigned FULL_BYTES = 8;
   localparam int unsigned IDX_PEND   = 0;
   localparam int unsigned IDX_MASK0  = 1;
   localparam int unsigned IDX_ROUTE0 = 8;

   typedef enum logic [1:0] {
      RC_PEND  = 2'd0,
      RC_MASK  = 2'd1,
      RC_ROUTE = 2'd2,
      RC_NONE  = 2'd3
   } reg_class_t;
endpackage

// File: rtl/irq_req_vec.sv
module irq_req_vec #(
   parameter int NSRC  = 64,
   parameter int NUM_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_vld,
   input  logic [NUM_W-1:0] set_num,
   input  logic            clr_vld,
   input  logic [NUM_W-1:0] clr_num,
   output logic [NSRC-1:0] pend_next,
   output logic [NSRC-1:0] pend_q,
   output logic            spur_q
);
   generate
      if (NSRC != (1 << NUM_W)) begin : g_bad_w
         $error("irq_req_vec: NSRC must equal 2**NUM_W");
      end
   endgenerate

   // clear first, then set (R4)
   always_comb begin
      pend_next = pend_q;
      if (clr_vld) pend_next[clr_num] = 1'b0;
      if (set_vld) pend_next[set_num] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         spur_q <= 1'b0;
      end else begin
         pend_q <= pend_next;
         spur_q <= clr_vld && !pend_q[clr_num];
      end
   end

   a_r2_set_lands : assert property (@(posedge clk) disable iff (!rst_n)
      set_vld |=> pend_q[$past(set_num)]);
   a_r3_clear_lands : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld && !(set_vld && set_num == clr_num)) |=> !pend_q[$past(clr_num)]);
   a_r3_spur_keeps : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld && !pend_q[clr_num] && !set_vld) |=> $stable(pend_q));
endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
   parameter int NSRC    = 64,
   parameter int DATA_W  = 64,
   parameter bit PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NSRC-1:0]   pend_next,
   input  logic [NSRC-1:0]   pend_q,
   output logic [NSRC-1:0]   mask_q,
   output logic [NSRC-1:0]   route_q,
   output logic [NSRC-1:0]   post_q,
   output logic [NSRC-1:0]   wdraw_q,
   output logic              irq
);
   logic [NSRC-1:0] mask_next;
   logic [NSRC-1:0] route_next;

   generate
      if (NSRC > DATA_W) begin : g_bad_w
         $error("irq_cpu_lane: NSRC must not exceed DATA_W");
      end
   endgenerate

   assign mask_next  = mask_we ? wdata[NSRC-1:0] : mask_q;
   assign route_next = mask_next & pend_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         route_q <= '0;
      end else begin
         mask_q  <= mask_next;
         route_q <= route_next;
      end
   end

   generate
      if (PRESENT) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               post_q  <= '0;
               wdraw_q <= '0;
            end else begin
               post_q  <= route_next & ~route_q;
               wdraw_q <= route_q & ~route_next;
            end
         end
         assign irq = |route_q;

         a_r6_post_rise : assert property (@(posedge clk) disable iff (!rst_n)
            post_q == (route_q & ~$past(route_q)));
         a_r6_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
            (post_q & wdraw_q) == '0);
      end else begin : g_absent
         assign post_q  = '0;
         assign wdraw_q = '0;
         assign irq     = 1'b0;
      end
   endgenerate

   a_r5_route_match : assert property (@(posedge clk) disable iff (!rst_n)
      route_q == (mask_q & pend_q));
endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
   import irq_router_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 64,
   parameter int NSRC    = 64,
   parameter int MAX_CPU = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [3:0]              bus_size,
   input  logic [NSRC-1:0]         pend_q,
   input  logic [MAX_CPU*NSRC-1:0] mask_flat,
   input  logic [MAX_CPU*NSRC-1:0] route_flat,
   output logic [MAX_CPU-1:0]      mask_we,
   output logic [DATA_W-1:0]       rdata,
   output logic                    rvalid,
   output logic                    size_err,
   output logic                    ro_err
);
   localparam int IDX_W = ADDR_W - 6;

   logic [IDX_W-1:0] idx;
   logic             size_ok;
   reg_class_t       rclass;
   int unsigned      sel;
   logic [DATA_W-1:0] rd_mux;

   assign idx     = bus_addr[ADDR_W-1:6];
   assign size_ok = (bus_size == 4'(FULL_BYTES));

   always_comb begin
      rclass = RC_NONE;
      sel    = 0;
      if (int'(idx) == IDX_PEND) begin
         rclass = RC_PEND;
      end else if (int'(idx) >= IDX_MASK0 && int'(idx) < IDX_MASK0 + MAX_CPU) begin
         rclass = RC_MASK;
         sel    = int'(idx) - IDX_MASK0;
      end else if (int'(idx) >= IDX_ROUTE0 && int'(idx) < IDX_ROUTE0 + MAX_CPU) begin
         rclass = RC_ROUTE;
         sel    = int'(idx) - IDX_ROUTE0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (rclass)
         RC_PEND:  rd_mux[NSRC-1:0] = pend_q;
         RC_MASK:  rd_mux[NSRC-1:0] = mask_flat[sel*NSRC +: NSRC];
         RC_ROUTE: rd_mux[NSRC-1:0] = route_flat[sel*NSRC +: NSRC];
         default:  rd_mux = '0;
      endcase
   end

   generate
      for (genvar c = 0; c < MAX_CPU; c++) begin : g_we
         assign mask_we[c] = bus_req && bus_we && size_ok &&
                             rclass == RC_MASK && sel == c;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         rvalid   <= 1'b0;
         size_err <= 1'b0;
         ro_err   <= 1'b0;
      end else begin
         rvalid   <= bus_req && !bus_we;
         rdata    <= (bus_req && !bus_we && size_ok) ? rd_mux : '0;
         size_err <= bus_req && !size_ok;
         ro_err   <= bus_req && bus_we && size_ok && rclass != RC_MASK;
      end
   end

   a_r10_size_flag : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_size != 4'(FULL_BYTES)) |=> size_err);
   a_r10_no_mask_change : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_size != 4'(FULL_BYTES)) |=> $stable(mask_flat));
   a_r11_ro_keeps_masks : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && size_ok && rclass != RC_MASK) |=> $stable(mask_flat));
   a_r9_read_valid : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> rvalid);
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int NSRC    = 64,
   parameter int MAX_CPU = 4,
   parameter int NUM_CPU = 4,
   parameter int DATA_W  = 64,
   parameter int ADDR_W  = 10,
   parameter int NUM_W   = $clog2(NSRC)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_set_vld,
   input  logic [NUM_W-1:0]        req_set_num,
   input  logic                    req_clr_vld,
   input  logic [NUM_W-1:0]        req_clr_num,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [3:0]              bus_size,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic                    bus_rvalid,
   output logic                    size_err,
   output logic                    ro_err,
   output logic                    spurious_clr,
   output logic [MAX_CPU-1:0]      cpu_irq,
   output logic [MAX_CPU*NSRC-1:0] post_evt,
   output logic [MAX_CPU*NSRC-1:0] wdraw_evt
);
   generate
      if (MAX_CPU < 1 || MAX_CPU > 4) begin : g_bad_max
         $error("irq_router: MAX_CPU must be 1..4");
      end
      if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_num
         $error("irq_router: NUM_CPU must be 1..MAX_CPU");
      end
      if (ADDR_W < 10) begin : g_bad_addr
         $error("irq_router: ADDR_W must be at least 10");
      end
   endgenerate

   logic [NSRC-1:0]         pend_next;
   logic [NSRC-1:0]         pend_q;
   logic [MAX_CPU-1:0]      mask_we;
   logic [MAX_CPU*NSRC-1:0] mask_flat;
   logic [MAX_CPU*NSRC-1:0] route_flat;

   irq_req_vec #(.NSRC(NSRC), .NUM_W(NUM_W)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .set_vld(req_set_vld), .set_num(req_set_num),
      .clr_vld(req_clr_vld), .clr_num(req_clr_num),
      .pend_next(pend_next), .pend_q(pend_q), .spur_q(spurious_clr)
   );

   generate
      for (genvar c = 0; c < MAX_CPU; c++) begin : g_lane
         irq_cpu_lane #(.NSRC(NSRC), .DATA_W(DATA_W), .PRESENT(c < NUM_CPU)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .mask_we(mask_we[c]), .wdata(bus_wdata),
            .pend_next(pend_next), .pend_q(pend_q),
            .mask_q(mask_flat[c*NSRC +: NSRC]),
            .route_q(route_flat[c*NSRC +: NSRC]),
            .post_q(post_evt[c*NSRC +: NSRC]),
            .wdraw_q(wdraw_evt[c*NSRC +: NSRC]),
            .irq(cpu_irq[c])
         );
      end
   endgenerate

   irq_csr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC), .MAX_CPU(MAX_CPU)) u_port (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
      .pend_q(pend_q), .mask_flat(mask_flat), .route_flat(route_flat),
      .mask_we(mask_we), .rdata(bus_rdata), .rvalid(bus_rvalid),
      .size_err(size_err), .ro_err(ro_err)
   );

   a_r1_quiet_flags : assert property (@(posedge clk) $past(!rst_n) |-> (cpu_irq == '0 && !spurious_clr));
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
   localparam int NC = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_set_vld = 0, req_clr_vld = 0;
   logic [5:0]   req_set_num = 0, req_clr_num = 0;
   logic         bus_req = 0, bus_we = 0;
   logic [9:0]   bus_addr = 0;
   logic [3:0]   bus_size = 8;
   logic [63:0]  bus_wdata = 0;
   logic [63:0]  bus_rdata;
   logic         bus_rvalid, size_err, ro_err, spurious_clr;
   logic [3:0]   cpu_irq;
   logic [255:0] post_evt, wdraw_evt;

   irq_router #(.NUM_CPU(NC)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_set_vld(req_set_vld), .req_set_num(req_set_num),
      .req_clr_vld(req_clr_vld), .req_clr_num(req_clr_num),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .size_err(size_err), .ro_err(ro_err), .spurious_clr(spurious_clr),
      .cpu_irq(cpu_irq), .post_evt(post_evt), .wdraw_evt(wdraw_evt)
   );

   always #2.5 clk = ~clk;

   int errors = 0, checks = 0;
   bit done = 0;

   // behavioural model state
   logic [63:0] m_pend = 0;
   logic [63:0] m_mask [4];
   logic [63:0] m_route [4];
   logic [63:0] e_post [4];
   logic [63:0] e_wd [4];
   logic [3:0]  e_irq = 0;
   logic        e_spur = 0, e_serr = 0, e_rerr = 0, e_rvalid = 0;
   logic [63:0] e_rdata = 0;

   function automatic logic [63:0] m_read(input int ix);
      if (ix == 0) return m_pend;
      if (ix >= 1 && ix <= 4) return m_mask[ix-1];
      if (ix >= 8 && ix <= 11) return m_route[ix-8];
      return 64'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; e_irq = 0; e_spur = 0; e_serr = 0; e_rerr = 0; e_rvalid = 0; e_rdata = 0;
         for (int c = 0; c < 4; c++) begin
            m_mask[c] = 0; m_route[c] = 0; e_post[c] = 0; e_wd[c] = 0;
         end
      end else begin
         int ix;
         logic [63:0] np;
         ix = int'(bus_addr) / 64;
         np = m_pend;
         e_spur = 0;
         if (req_clr_vld) begin
            if (np[req_clr_num] == 1'b0) e_spur = 1;
            np[req_clr_num] = 1'b0;
         end
         if (req_set_vld) np[req_set_num] = 1'b1;
         e_rvalid = bus_req && !bus_we;
         e_serr   = bus_req && bus_size != 8;
         e_rerr   = 0;
         e_rdata  = 0;
         if (bus_req && !bus_we && bus_size == 8) e_rdata = m_read(ix);
         if (bus_req && bus_we && bus_size == 8) begin
            if (ix >= 1 && ix <= 4) m_mask[ix-1] = bus_wdata;
            else e_rerr = 1;
         end
         m_pend = np;
         for (int c = 0; c < 4; c++) begin
            logic [63:0] nr;
            nr = 0;
            for (int b = 0; b < 64; b++) nr[b] = m_mask[c][b] && m_pend[b];
            e_post[c] = 0; e_wd[c] = 0;
            if (c < NC) begin
               for (int b = 0; b < 64; b++) begin
                  if (nr[b] && !m_route[c][b]) e_post[c][b] = 1;
                  if (!nr[b] && m_route[c][b]) e_wd[c][b] = 1;
               end
            end
            m_route[c] = nr;
            e_irq[c] = (c < NC) && (nr != 0);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cpu_irq == e_irq, "R7 cpu_irq level", 64'(cpu_irq), 64'(e_irq));
         chk(spurious_clr == e_spur, "R3 spurious pulse", 64'(spurious_clr), 64'(e_spur));
         chk(size_err == e_serr, "R10 size error", 64'(size_err), 64'(e_serr));
         chk(ro_err == e_rerr, "R11 read-only error", 64'(ro_err), 64'(e_rerr));
         chk(bus_rvalid == e_rvalid, "R9 read valid", 64'(bus_rvalid), 64'(e_rvalid));
         if (e_rvalid)
            chk(bus_rdata == e_rdata, "R8 read data", bus_rdata, e_rdata);
         for (int c = 0; c < 4; c++) begin
            chk(post_evt[c*64 +: 64] == e_post[c], "R6 post vector", post_evt[c*64 +: 64], e_post[c]);
            chk(wdraw_evt[c*64 +: 64] == e_wd[c], "R6 withdraw vector", wdraw_evt[c*64 +: 64], e_wd[c]);
         end
      end
   end

   task automatic idle();
      req_set_vld = 0; req_clr_vld = 0; bus_req = 0; bus_we = 0; bus_size = 8;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic wr(input int ix, input logic [63:0] d, input logic [3:0] sz = 8);
      bus_req = 1; bus_we = 1; bus_addr = 10'(ix * 64); bus_wdata = d; bus_size = sz;
      step();
   endtask

   task automatic rd_chk(input int ix, input logic [63:0] exp, input string tag, input logic [5:0] low = 0);
      bus_req = 1; bus_we = 0; bus_addr = 10'(ix * 64) | 10'(low); bus_size = 8;
      step();
      chk(bus_rvalid && bus_rdata == exp, tag, bus_rdata, exp);
   endtask

   task automatic set_line(input int n);
      req_set_vld = 1; req_set_num = 6'(n);
      step();
   endtask

   task automatic clr_line(input int n);
      req_clr_vld = 1; req_clr_num = 6'(n);
      step();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] s;
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle();
      // R1: reset state seen at the ports
      chk(cpu_irq == 0 && post_evt == 0 && wdraw_evt == 0, "R1 outputs after reset", 64'(cpu_irq), 0);
      rd_chk(0, 64'd0, "R1 pending after reset");
      rd_chk(2, 64'd0, "R1 mask after reset");
      rd_chk(9, 64'd0, "R1 routed after reset");

      // masks then requests (R2, R5)
      wr(1, 64'h0000_0000_0000_00FF);
      wr(2, 64'hFF00_0000_0000_0000);
      wr(4, 64'hFFFF_FFFF_FFFF_FFFF);
      set_line(3);
      rd_chk(0, 64'h8, "R2 pending bit 3");
      set_line(63);
      rd_chk(8, 64'h8, "R5 routed cpu0");
      rd_chk(9, 64'h8000_0000_0000_0000, "R5 routed cpu1");
      rd_chk(11, 64'h8000_0000_0000_0008, "R7 absent lane routed stored");
      chk(cpu_irq == 4'b0011, "R7 irq with absent lane", 64'(cpu_irq), 64'h3);

      // R3 clear and spurious clear
      clr_line(3);
      rd_chk(0, 64'h8000_0000_0000_0000, "R3 pending after clear");
      clr_line(5);
      rd_chk(0, 64'h8000_0000_0000_0000, "R3 spurious clear ignored");

      // R4 same-cycle set and clear on one number
      req_set_vld = 1; req_set_num = 6'd7; req_clr_vld = 1; req_clr_num = 6'd7;
      step();
      rd_chk(0, 64'h8000_0000_0000_0080, "R4 set wins over clear");

      // R6 mask rewrite adds and removes routed bits
      wr(1, 64'h0000_0000_0000_0100);
      set_line(8);
      wr(1, 64'h8000_0000_0000_0080);
      rd_chk(8, 64'h8000_0000_0000_0080, "R6 routed after remask");

      // R8 low address bits ignored
      rd_chk(1, 64'h8000_0000_0000_0080, "R8 low bits ignored", 6'h2F);
      rd_chk(12, 64'd0, "R8 unmapped reads zero");

      // R10 bad size write leaves mask, R11 write to read-only leaves state
      wr(1, 64'h1, 4'd4);
      rd_chk(1, 64'h8000_0000_0000_0080, "R10 bad-size write ignored");
      bus_req = 1; bus_we = 0; bus_addr = 10'h40; bus_size = 4'd2;
      step();
      chk(bus_rdata == 0 && size_err, "R10 bad-size read zero", bus_rdata, 0);
      wr(0, 64'd0);
      rd_chk(0, 64'h8000_0000_0000_0180, "R11 pending write ignored");
      wr(9, 64'd0);
      rd_chk(9, 64'h8000_0000_0000_0000, "R11 routed write ignored");

      // pseudo-random phase: colliding strobes and mask writes (R5, R6)
      s = 32'h1234_5678;
      for (int i = 0; i < 3000; i++) begin
         s ^= s << 13; s ^= s >> 17; s ^= s << 5;
         req_set_vld = s[0]; req_set_num = {3'b0, s[3:1]};
         req_clr_vld = s[4]; req_clr_num = {3'b0, s[7:5]};
         if (s[8] && s[9]) begin
            bus_req = 1; bus_we = s[10];
            bus_addr = {s[14:11], s[20:15]};
            bus_size = s[21] && s[22] && s[23] ? 4'd4 : 4'd8;
            bus_wdata = {s, s[31:16], s[15:0]} ^ {32'd0, s};
         end
         step();
      end
      idle();
      step();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule